// File: doc/BRIEF.md
# Octal DDR Command and Address Sequencer

This block is the host-side engine that opens, carries and closes one transaction on an eight-bit double-data-rate bus to a pseudo-static RAM. It takes one request: an operation, a 32-bit address, a byte length and the two latency settings. It pulls the active-low select down and drives the instruction byte on both halves of the first memory clock. It then drives the four address bytes on the two halves of each of the next two clocks, most significant first. After that it waits the configured number of latency clocks with the bus released. Last it moves data at two bytes per clock: it drives write bytes with a byte-mask line, or it captures read bytes on each transition of the strobe that the memory returns.

The block clock runs at twice the memory clock. Every block clock cycle is one half-cycle slot, and the output `ck_rise` tells whether the current slot is the rising or the falling half. Pad buffers, the real DDR registers and clock generation sit outside. The block has seven states. IDLE waits for a request. CMD covers the two instruction slots. ADDR covers the four address slots. LAT covers the latency slots. WDATA and RDATA move the data. DONE is a one-slot close with the select high.

The transitions are:
- IDLE→CMD when a request with a legal operation is presented.
- CMD→ADDR, or CMD→DONE for global reset.
- ADDR→LAT when the latency is not zero.
- ADDR→WDATA or ADDR→RDATA when the latency is zero.
- ADDR→DONE for a read of length zero.
- LAT→WDATA or LAT→RDATA when the latency has run out.
- WDATA→DONE after the last padded slot.
- RDATA→DONE on the strobe edge of the last byte.
- DONE→IDLE.

Top module: `oct_ddr_seq`

## Requirements
- R1: After reset `cs_n`=1, `dq_oe`=0, `dqs_dm_oe`=0, `done`=0, `rd_valid`=0 and `req_ready`=1.
- R2: `req_op` encodes the operation and its instruction byte as follows: 0 sync read 00h, 1 sync write 80h, 2 linear read 20h, 3 linear write A0h, 4 register read 40h, 5 register write C0h, 6 global reset FFh. The byte is driven with `dq_oe`=1 in the first two slots after acceptance, and `cs_n` is low from the first of those slots.
- R3: For array operations, the four slots after the instruction carry address bits [31:24], [23:16], [15:8] and [7:0], in that order.
- R4: Register operations drive 00h in the first three address slots and address bits [7:0] in the fourth. Global reset drives no address and goes to DONE straight after its two instruction slots.
- R5: After the address, the block spends 2×L slots with `cs_n`=0 and `dq_oe`=0. L is `rd_lat` for reads and `wr_lat` for writes, sampled when the request is accepted. L=0 skips the phase.
- R6: In a write, each data slot drives `dq_out`=`wr_data` and `dqs_dm_out`=`wr_mask` (1 means do not write), with `dq_oe`=1, `dqs_dm_oe`=1 and `wr_ready`=1. The slot count is `req_len` rounded up to even.
- R7: A write of odd length gets one pad slot, and a write of length 0 gets two pad slots. In a pad slot `dq_out`=00h, `dqs_dm_out`=1 and `wr_ready`=0.
- R8: In a read, the block captures `dq_in` on every slot in which `dqs_in` differs from its value in the slot before. It presents the byte on `rd_data` with `rd_valid`=1 in the next slot. Slots with no strobe change give no byte and do not end the read.
- R9: `done` is high for exactly one slot. `cs_n` is high in that slot, and `req_ready` returns in the slot after it. In a read, `done` coincides with `rd_valid` for the last byte.
- R10: `ck_rise` is 1 in the first instruction slot and alternates in every slot while `cs_n` is low. Data phases therefore start on a rising half.
- R11: A read of length 0 goes from the last address slot straight to DONE, with no latency phase.
- R12: A request with `req_op`=7 is ignored: `cs_n` stays 1 and `req_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, two per memory clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | 32 | Byte address or register address |
| req_len | input | 11 | Data length in bytes |
| rd_lat | input | 3 | Read latency in memory clocks |
| wr_lat | input | 3 | Write latency in memory clocks |
| wr_data | input | 8 | Write byte for the current slot |
| wr_mask | input | 1 | Mask for the current byte, 1 = skip |
| wr_ready | output | 1 | Current slot consumes `wr_data` |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | `rd_data` is valid |
| done | output | 1 | Transaction closes this slot |
| cs_n | output | 1 | Chip select, active low |
| ck_rise | output | 1 | Current slot is the rising half |
| dq_out | output | 8 | Bus value driven to memory |
| dq_oe | output | 1 | Bus output enable |
| dq_in | input | 8 | Bus value from memory |
| dqs_dm_out | output | 1 | Data mask driven during writes |
| dqs_dm_oe | output | 1 | Mask output enable |
| dqs_in | input | 1 | Read strobe from memory |

## Verification
Directed transactions cover each operation once, so the instruction byte, the address order and the register and reset header forms are each seen alone. Lengths of 0, 1 and odd values separate correct write padding from plain length counting, and zero and non-zero latencies show whether the release phase is sized from the right latency. Reads are fed with randomly stalled strobes, which shows whether capture follows strobe transitions rather than slot count. A seeded random mix of operations, addresses, lengths and latencies then runs back to back, which checks that state does not leak from one transaction into the next.

// File: rtl/oct_seq_pkg.sv
package oct_seq_pkg;

    typedef enum logic [2:0] {
        OP_SYNC_RD  = 3'd0,
        OP_SYNC_WR  = 3'd1,
        OP_LIN_RD   = 3'd2,
        OP_LIN_WR   = 3'd3,
        OP_REG_RD   = 3'd4,
        OP_REG_WR   = 3'd5,
        OP_GLB_RST  = 3'd6,
        OP_ILLEGAL  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_CMD   = 3'd1,
        S_ADDR  = 3'd2,
        S_LAT   = 3'd3,
        S_WDATA = 3'd4,
        S_RDATA = 3'd5,
        S_DONE  = 3'd6
    } st_e;

    localparam int CMD_SLOTS = 2;

    function automatic logic [7:0] op_code(input op_e op);
        unique case (op)
            OP_SYNC_RD: op_code = 8'h00;
            OP_SYNC_WR: op_code = 8'h80;
            OP_LIN_RD:  op_code = 8'h20;
            OP_LIN_WR:  op_code = 8'hA0;
            OP_REG_RD:  op_code = 8'h40;
            OP_REG_WR:  op_code = 8'hC0;
            OP_GLB_RST: op_code = 8'hFF;
            default:    op_code = 8'hFF;
        endcase
    endfunction

    function automatic logic op_is_read(input op_e op);
        op_is_read = (op == OP_SYNC_RD) || (op == OP_LIN_RD) || (op == OP_REG_RD);
    endfunction

    function automatic logic op_is_reg(input op_e op);
        op_is_reg = (op == OP_REG_RD) || (op == OP_REG_WR);
    endfunction

    function automatic logic op_legal(input logic [2:0] code);
        op_legal = (code != 3'd7);
    endfunction

endpackage

// File: rtl/oct_hdr_mux.sv
module oct_hdr_mux
    import oct_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    localparam int NBYTES = ADDR_W / 8,
    localparam int SLOT_W = $clog2(CMD_SLOTS + NBYTES),
    localparam int AIDX_W = $clog2(NBYTES)
) (
    input  op_e                op,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [SLOT_W-1:0]  slot,
    output logic [7:0]         hdr_byte
);

    logic [7:0]        abyte [NBYTES];
    logic [AIDX_W-1:0] idx;

    // Address bytes, most significant first
    for (genvar gi = 0; gi < NBYTES; gi++) begin : g_abyte
        assign abyte[gi] = addr[ADDR_W-1-8*gi -: 8];
    end

    assign idx = AIDX_W'(slot - SLOT_W'(CMD_SLOTS));

    always_comb begin
        if (slot < SLOT_W'(CMD_SLOTS)) begin
            hdr_byte = op_code(op);
        end else if (op_is_reg(op)) begin
            hdr_byte = (idx == AIDX_W'(NBYTES - 1)) ? abyte[NBYTES-1] : 8'h00;
        end else begin
            hdr_byte = abyte[idx];
        end
    end

endmodule

// File: rtl/oct_rd_capture.sv
module oct_rd_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          strobe_in,
    input  logic [DW-1:0] bus_in,
    output logic          cap_edge,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);

    logic strobe_q;

    assign cap_edge = en && (strobe_in != strobe_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            strobe_q <= strobe_in;
            rd_valid <= cap_edge;
            if (cap_edge) begin
                rd_data <= bus_in;
            end
        end
    end

    // R8: no byte appears unless capture was enabled one slot earlier
    p_capture_only_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(en));

endmodule

// File: rtl/oct_seq_fsm.sv
module oct_seq_fsm
    import oct_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 11,
    parameter int LAT_W  = 3,
    localparam int NBYTES = ADDR_W / 8,
    localparam int SLOT_W = $clog2(CMD_SLOTS + NBYTES),
    localparam int CW     = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [LAT_W-1:0]  rd_lat,
    input  logic [LAT_W-1:0]  wr_lat,
    input  logic              cap_edge,
    input  logic [7:0]        hdr_byte,
    input  logic [7:0]        wr_data,
    input  logic              wr_mask,
    output logic              req_ready,
    output op_e               op_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [SLOT_W-1:0] hdr_slot,
    output logic              cap_en,
    output logic              wr_ready,
    output logic              done,
    output logic              cs_n,
    output logic              ck_rise,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    output logic              dm_out,
    output logic              dm_oe
);

    st_e               st, st_n;
    logic [CW-1:0]     cnt;
    logic              phase;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [LAT_W-1:0]  lat_q;

    logic [CW-1:0]     lat_slots;
    logic [CW-1:0]     wr_slots;
    logic [CW-1:0]     len_ext;
    logic              in_len;
    logic              is_rd;
    logic              active;
    st_e               data_st;

    assign len_ext   = CW'(len_q);
    assign lat_slots = CW'({lat_q, 1'b0});
    assign wr_slots  = (len_q == '0) ? CW'(2) : ((len_ext + CW'(1)) & ~CW'(1));
    assign in_len    = cnt < len_ext;
    assign is_rd     = op_is_read(op_q);
    assign data_st   = is_rd ? S_RDATA : S_WDATA;
    assign active    = (st != S_IDLE) && (st != S_DONE);

    // Next-state decision
    always_comb begin
        st_n = st;
        unique case (st)
            S_IDLE: begin
                if (req_valid && op_legal(req_op)) st_n = S_CMD;
            end
            S_CMD: begin
                if (cnt == CW'(CMD_SLOTS - 1)) begin
                    st_n = (op_q == OP_GLB_RST) ? S_DONE : S_ADDR;
                end
            end
            S_ADDR: begin
                if (cnt == CW'(NBYTES - 1)) begin
                    if (is_rd && (len_q == '0)) st_n = S_DONE;
                    else if (lat_q == '0)       st_n = data_st;
                    else                        st_n = S_LAT;
                end
            end
            S_LAT: begin
                if (cnt == lat_slots - CW'(1)) st_n = data_st;
            end
            S_WDATA: begin
                if (cnt == wr_slots - CW'(1)) st_n = S_DONE;
            end
            S_RDATA: begin
                if (cap_edge && (cnt == len_ext - CW'(1))) st_n = S_DONE;
            end
            S_DONE: begin
                st_n = S_IDLE;
            end
            default: st_n = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    // Slot counter, half-clock phase and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            phase  <= 1'b0;
            op_q   <= OP_SYNC_RD;
            addr_q <= '0;
            len_q  <= '0;
            lat_q  <= '0;
        end else begin
            if (st == S_IDLE) begin
                phase <= 1'b0;
                if (st_n == S_CMD) begin
                    op_q   <= op_e'(req_op);
                    addr_q <= req_addr;
                    len_q  <= req_len;
                    lat_q  <= op_is_read(op_e'(req_op)) ? rd_lat : wr_lat;
                end
            end else if (active) begin
                phase <= ~phase;
            end
            if (st_n != st)          cnt <= '0;
            else if (st == S_RDATA)  cnt <= cnt + CW'(cap_edge);
            else if (active)         cnt <= cnt + CW'(1);
        end
    end

    assign op_o     = op_q;
    assign addr_o   = addr_q;
    assign hdr_slot = (st == S_CMD) ? SLOT_W'(cnt) : SLOT_W'(cnt + CW'(CMD_SLOTS));

    // Outputs from state
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        cs_n      = 1'b1;
        ck_rise   = 1'b0;
        dq_out    = 8'h00;
        dq_oe     = 1'b0;
        dm_out    = 1'b0;
        dm_oe     = 1'b0;
        wr_ready  = 1'b0;
        cap_en    = 1'b0;
        unique case (st)
            S_IDLE: begin
                req_ready = 1'b1;
            end
            S_CMD, S_ADDR: begin
                cs_n    = 1'b0;
                ck_rise = ~phase;
                dq_oe   = 1'b1;
                dq_out  = hdr_byte;
            end
            S_LAT: begin
                cs_n    = 1'b0;
                ck_rise = ~phase;
            end
            S_WDATA: begin
                cs_n     = 1'b0;
                ck_rise  = ~phase;
                dq_oe    = 1'b1;
                dm_oe    = 1'b1;
                wr_ready = in_len;
                dq_out   = in_len ? wr_data : 8'h00;
                dm_out   = in_len ? wr_mask : 1'b1;
            end
            S_RDATA: begin
                cs_n    = 1'b0;
                ck_rise = ~phase;
                cap_en  = 1'b1;
            end
            S_DONE: begin
                done = 1'b1;
            end
            default: ;
        endcase
    end

    // R6: bus is never driven without the select low
    p_oe_needs_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !cs_n);
    // R9: done lasts one slot
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: done slot has select released
    p_done_cs_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);
    // R10: half-clock marker alternates while selected
    p_clk_alternates_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> (ck_rise != $past(ck_rise)));
    // R2 / R10: the first instruction slot is a rising half
    p_hdr_first_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(req_ready)) |-> (ck_rise && dq_oe));
    // R5: bus released during latency
    p_lat_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_LAT) |-> (!dq_oe && !cs_n));
    // R7: pad slots are masked
    p_pad_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_oe && !wr_ready) |-> dm_out);
    // R12: an illegal operation leaves the sequencer idle
    p_bad_op_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && (req_op == 3'd7)) |=> (req_ready && cs_n));

endmodule

// File: rtl/oct_ddr_seq.sv
module oct_ddr_seq
    import oct_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 11,
    parameter int LAT_W  = 3,
    localparam int NBYTES = ADDR_W / 8,
    localparam int SLOT_W = $clog2(CMD_SLOTS + NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [LAT_W-1:0]  rd_lat,
    input  logic [LAT_W-1:0]  wr_lat,
    input  logic [7:0]        wr_data,
    input  logic              wr_mask,
    output logic              wr_ready,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              done,
    output logic              cs_n,
    output logic              ck_rise,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    input  logic [7:0]        dq_in,
    output logic              dqs_dm_out,
    output logic              dqs_dm_oe,
    input  logic              dqs_in
);

    op_e               op_w;
    logic [ADDR_W-1:0] addr_w;
    logic [SLOT_W-1:0] slot_w;
    logic [7:0]        hdr_w;
    logic              cap_en_w;
    logic              cap_edge_w;

    oct_seq_fsm #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .LAT_W  (LAT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .rd_lat    (rd_lat),
        .wr_lat    (wr_lat),
        .cap_edge  (cap_edge_w),
        .hdr_byte  (hdr_w),
        .wr_data   (wr_data),
        .wr_mask   (wr_mask),
        .req_ready (req_ready),
        .op_o      (op_w),
        .addr_o    (addr_w),
        .hdr_slot  (slot_w),
        .cap_en    (cap_en_w),
        .wr_ready  (wr_ready),
        .done      (done),
        .cs_n      (cs_n),
        .ck_rise   (ck_rise),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .dm_out    (dqs_dm_out),
        .dm_oe     (dqs_dm_oe)
    );

    oct_hdr_mux #(
        .ADDR_W (ADDR_W)
    ) u_hdr (
        .op       (op_w),
        .addr     (addr_w),
        .slot     (slot_w),
        .hdr_byte (hdr_w)
    );

    oct_rd_capture #(
        .DW (8)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cap_en_w),
        .strobe_in (dqs_in),
        .bus_in    (dq_in),
        .cap_edge  (cap_edge_w),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/oct_ddr_seq_bench.sv
module oct_ddr_seq_bench;

    localparam int LEN_W = 11;
    localparam int LAT_W = 3;
    localparam int WDOG  = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [2:0]        req_op = '0;
    logic [31:0]       req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [LAT_W-1:0]  rd_lat = '0;
    logic [LAT_W-1:0]  wr_lat = '0;
    logic [7:0]        wr_data = '0;
    logic              wr_mask = 1'b0;
    logic              wr_ready;
    logic [7:0]        rd_data;
    logic              rd_valid;
    logic              done;
    logic              cs_n;
    logic              ck_rise;
    logic [7:0]        dq_out;
    logic              dq_oe;
    logic [7:0]        dq_in = '0;
    logic              dqs_dm_out;
    logic              dqs_dm_oe;
    logic              dqs_in = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    logic tog = 1'b0;

    always #4 clk = ~clk;

    oct_ddr_seq u_oct_ddr_seq (
        .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_addr, .req_len,
        .rd_lat, .wr_lat, .wr_data, .wr_mask, .wr_ready, .rd_data, .rd_valid,
        .done, .cs_n, .ck_rise, .dq_out, .dq_oe, .dq_in, .dqs_dm_out,
        .dqs_dm_oe, .dqs_in
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_opc(input logic [2:0] op);
        case (op)
            3'd0: return 8'h00;
            3'd1: return 8'h80;
            3'd2: return 8'h20;
            3'd3: return 8'hA0;
            3'd4: return 8'h40;
            3'd5: return 8'hC0;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic bit is_rd(input logic [2:0] op);
        return (op == 3'd0) || (op == 3'd2) || (op == 3'd4);
    endfunction

    function automatic logic [7:0] exp_hdr(input logic [2:0] op, input logic [31:0] a, input int s);
        if (s < 2) return exp_opc(op);
        if (op == 3'd4 || op == 3'd5) return (s == 5) ? a[7:0] : 8'h00;
        return a[31 - 8*(s-2) -: 8];
    endfunction

    function automatic logic [7:0] data_byte(input logic [31:0] a, input int i);
        return a[7:0] ^ 8'(i * 37) ^ 8'h5A;
    endfunction

    task automatic run(input logic [2:0] op, input logic [31:0] a, input int len,
                       input int lat, input int stall_pct);
        int nh;
        int ws;
        bit fire;
        logic [7:0] last_b;
        @(negedge clk);
        req_op = op; req_addr = a; req_len = LEN_W'(len);
        rd_lat = LAT_W'(lat); wr_lat = LAT_W'(lat);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rd_lat = LAT_W'(lat + 1); wr_lat = LAT_W'(lat + 2); // must not matter (R5)
        nh = (op == 3'd6) ? 2 : 6;
        for (int s = 0; s < nh; s++) begin
            if (s > 0) @(negedge clk);
            chk(s < 2 ? "R2 cs" : "R3 cs", 32'(cs_n), 32'd0);
            chk(s < 2 ? "R2 oe" : "R3 oe", 32'(dq_oe), 32'd1);
            chk((op >= 3'd4) ? "R4 hdr" : (s < 2 ? "R2 opc" : "R3 addr"),
                32'(dq_out), 32'(exp_hdr(op, a, s)));
            chk("R10 phase", 32'(ck_rise), 32'((s % 2) == 0));
        end
        if (op == 3'd6 || (is_rd(op) && len == 0)) begin
            @(negedge clk);
            chk(op == 3'd6 ? "R4 rst done" : "R11 done", 32'(done), 32'd1);
            chk("R9 cs high", 32'(cs_n), 32'd1);
            @(negedge clk);
            chk("R9 ready", 32'(req_ready), 32'd1);
            return;
        end
        for (int k = 0; k < 2*lat; k++) begin
            @(negedge clk);
            chk("R5 released", 32'({dq_oe, cs_n, done}), 32'd0);
        end
        if (!is_rd(op)) begin
            ws = (len == 0) ? 2 : ((len + 1) & ~1);
            for (int i = 0; i < ws; i++) begin
                logic [7:0] d;
                logic m;
                @(negedge clk);
                d = data_byte(a, i);
                m = 1'($urandom_range(0, 1));
                wr_data = d; wr_mask = m;
                #1;
                chk("R6 oe", 32'({dq_oe, dqs_dm_oe, cs_n}), 32'b110);
                chk("R10 data phase", 32'(ck_rise), 32'((i % 2) == 0));
                if (i < len) begin
                    chk("R6 data", 32'(dq_out), 32'(d));
                    chk("R6 mask", 32'(dqs_dm_out), 32'(m));
                    chk("R6 ready", 32'(wr_ready), 32'd1);
                end else begin
                    chk("R7 pad data", 32'(dq_out), 32'd0);
                    chk("R7 pad mask", 32'(dqs_dm_out), 32'd1);
                    chk("R7 pad ready", 32'(wr_ready), 32'd0);
                end
            end
            @(negedge clk);
            chk("R9 done", 32'(done), 32'd1);
            chk("R9 cs high", 32'(cs_n), 32'd1);
        end else begin
            int i = 0;
            fire = 1'b0;
            last_b = '0;
            forever begin
                @(negedge clk);
                if (fire) begin
                    chk("R8 valid", 32'(rd_valid), 32'd1);
                    chk("R8 data", 32'(rd_data), 32'(last_b));
                end else begin
                    chk("R8 no valid", 32'(rd_valid), 32'd0);
                end
                if (i == len && fire) begin
                    chk("R9 done with last", 32'(done), 32'd1);
                    chk("R9 cs high", 32'(cs_n), 32'd1);
                    break;
                end
                chk("R8 released", 32'({dq_oe, cs_n, done}), 32'd0);
                fire = ($urandom_range(0, 99) >= stall_pct);
                if (fire) begin
                    last_b = data_byte(a, i) ^ 8'hC3;
                    dq_in = last_b;
                    tog = ~tog;
                    dqs_in = tog;
                    i++;
                end else begin
                    dq_in = ~dq_in; // noise without a strobe edge
                end
            end
        end
        @(negedge clk);
        chk("R9 ready", 32'(req_ready), 32'd1);
        chk("R9 done single", 32'(done), 32'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WDOG) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, WDOG);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cs", 32'(cs_n), 32'd1);
        chk("R1 oe", 32'({dq_oe, dqs_dm_oe}), 32'd0);
        chk("R1 done", 32'({done, rd_valid}), 32'd0);
        chk("R1 ready", 32'(req_ready), 32'd1);
        rst_n = 1'b1;
        // R12 illegal operation ignored
        @(negedge clk);
        req_op = 3'd7; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12 cs", 32'(cs_n), 32'd1);
        chk("R12 ready", 32'(req_ready), 32'd1);
        @(negedge clk);
        chk("R12 still idle", 32'({cs_n, dq_oe}), 32'b10);
        // Directed corner cases
        run(3'd1, 32'h1234_5678, 4, 2, 0);   // sync write
        run(3'd0, 32'h89AB_CDEF, 5, 3, 40);  // sync read with stalls
        run(3'd2, 32'h0000_0102, 3, 0, 0);   // linear read, zero latency
        run(3'd3, 32'hFEDC_BA98, 1, 1, 0);   // R7 one byte write
        run(3'd1, 32'h0000_0010, 0, 0, 0);   // R7 zero length write
        run(3'd0, 32'h0000_0004, 0, 2, 0);   // R11 empty read
        run(3'd4, 32'hAABB_CC08, 2, 1, 20);  // R4 register read
        run(3'd5, 32'h5566_7704, 2, 0, 0);   // R4 register write
        run(3'd6, 32'hDEAD_BEEF, 0, 2, 0);   // R4 global reset
        run(3'd3, 32'h0F0F_0F0F, 7, 7, 0);   // R5 maximum latency
        // Seeded random mix
        for (int t = 0; t < 60; t++) begin
            run(3'($urandom_range(0, 6)), $urandom, $urandom_range(0, 24),
                $urandom_range(0, 4), $urandom_range(0, 60));
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule